// File: doc/BRIEF.md
# Dual-Modulus Pulse-Swallow Feedback Divider

This block divides a fast feedback clock by a programmable integer N and sends one pulse per N input cycles to a phase detector. It does not use one wide binary counter. A dual-modulus prescaler runs at the input rate and divides by 32 or 33. A 5-bit swallow count and a 10-bit main count then decide, prescaler cycle by prescaler cycle, which modulus to use. The resulting ratio is N = 32·B + A, where A is the swallow value and B is the main value. Every N from 992 to 32767 is reachable without gaps, and smaller ratios work whenever B ≥ A.

The divide setting (`swallow_a`, `main_b`) is sampled only at period boundaries, so a change never produces a partial period. Two inputs hold the counters at their start-of-period state with the output silenced: power-down (`pwr_dn`) and the synchronous reset request (`srst`). When the hold is released, counting restarts from a known point, so the first pulse comes an exact number of cycles later. This keeps the divider aligned with a reference divider released at the same time.

An illegal setting is never divided silently by some undefined ratio. If A exceeds B, A is clamped to B. If B is zero, B is treated as 1. In both cases `cfg_err` is raised for as long as the clamped setting is in force. All pins are plain control and status signals. The block has no streaming interface and applies no back-pressure.

Top module: `fbdiv_pswallow`

## Requirements
- R1: With 1 ≤ B and A ≤ B, consecutive `div_pulse` assertions are exactly 32·B + A clock cycles apart, and `cfg_err` is low.
- R2: The prescaler divides by 33 for the first A prescaler cycles of each output period and by 32 for the remaining B − A cycles. This makes the ratios 992 (B=31, A=0), 1023 (B=31, A=31), 1024 (B=32, A=0) and 32767 (B=1023, A=31) all exact.
- R3: `div_pulse` is high for exactly one clock cycle per output period.
- R4: A new A or B value presented mid-period does not alter the period in progress. It takes effect from the next full period onward.
- R5: While `pwr_dn` is high, `div_pulse` stays low and the counters are held at their start state. After `pwr_dn` is sampled low at a rising edge (counted as edge 1), the first pulse is high just after rising edge N.
- R6: A one-cycle `srst` pulse at any point in a period restarts the count. Counting edges from the first edge at which `srst` is sampled low, the next pulse is high just after edge N.
- R7: If A > B (with B ≥ 1), the divider uses A = B, giving N = 33·B, and `cfg_err` is high while that setting is in force.
- R8: If B = 0, the divider uses B = 1 and A = min(A, 1), giving N = 32 or 33, and `cfg_err` is high.
- R9: While `rst_n` is low, `div_pulse` and `cfg_err` are low. After `rst_n` rises with no hold active, the first pulse is high just after rising edge N + 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Feedback clock to be divided |
| rst_n | input | 1 | Asynchronous active-low reset |
| srst | input | 1 | Synchronous reset request; restarts the period |
| pwr_dn | input | 1 | Power-down; holds counters at start, silences output |
| swallow_a | input | 5 | Swallow count A (cycles at modulus 33) |
| main_b | input | 10 | Main count B (total prescaler cycles per period) |
| div_pulse | output | 1 | One-cycle pulse per N input cycles |
| cfg_err | output | 1 | High while a clamped setting (A > B or B = 0) is in force |

## Verification
The bench measures the distance between pulses at the extreme ratios 992, 1023, 1024 and 32767. A modulus steered by the wrong count, or an off-by-one in the swallow phase, would shift those distances by one or more cycles.

It changes the setting partway through a period and checks that the running period keeps the old length. A design that loaded the setting immediately would emit a short or long transitional period.

It measures the first pulse after power-down, after a mid-period reset request, and after asynchronous reset. A design that did not clear the prescaler phase would be misaligned by up to one prescaler cycle.

It also checks that A > B and B = 0 give the clamped ratio with `cfg_err` raised. A design without the clamp would divide by a ratio that does not fit the 32·B + A form, or would hang with a zero main count.

// File: rtl/fbdiv_pkg.sv
package fbdiv_pkg;

  // Default field widths of the divide setting.
  localparam int unsigned DEF_A_W = 5;
  localparam int unsigned DEF_B_W = 10;

  // Prescaler modulus selection.
  typedef enum logic {
    MOD_LO = 1'b0,   // divide by 2**A_W
    MOD_HI = 1'b1    // divide by 2**A_W + 1
  } modsel_e;

endpackage

// File: rtl/fbdiv_setting.sv
module fbdiv_setting
  import fbdiv_pkg::*;
#(
  parameter int unsigned A_W = DEF_A_W,
  parameter int unsigned B_W = DEF_B_W
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           load,
  input  logic [A_W-1:0] a_in,
  input  logic [B_W-1:0] b_in,
  output logic [A_W-1:0] a_nxt,
  output logic [A_W-1:0] a_eff,
  output logic [B_W-1:0] b_eff,
  output logic           err_q
);

  logic [B_W-1:0] b_nz;
  logic [B_W-1:0] a_wide;
  logic           a_over;
  logic           b_zero;

  // Legalise the raw setting: B of zero becomes 1, A larger than B is cut to B.
  always_comb begin
    b_zero = (b_in == '0);
    b_nz   = b_zero ? B_W'(1) : b_in;
    a_wide = B_W'(a_in);
    a_over = (a_wide > b_nz);
    a_nxt  = a_over ? b_nz[A_W-1:0] : a_in;
  end

  // Shadow copy of the setting in force for the current period.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_eff <= '0;
      b_eff <= B_W'(1);
      err_q <= 1'b0;
    end else if (load) begin
      a_eff <= a_nxt;
      b_eff <= b_nz;
      err_q <= b_zero | (a_wide > b_in);
    end
  end

  // R7: the swallow count in force never exceeds the main count in force
  p_clamp_r7: assert property (@(posedge clk) disable iff (!rst_n)
    B_W'(a_eff) <= b_eff);

  // R8: the main count in force is never zero
  p_b_nonzero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    b_eff != '0);

endmodule

// File: rtl/fbdiv_prescaler.sv
module fbdiv_prescaler
  import fbdiv_pkg::*;
#(
  parameter int unsigned A_W = DEF_A_W
) (
  input  logic    clk,
  input  logic    rst_n,
  input  logic    hold,
  input  modsel_e modsel,
  output logic    tick
);

  localparam int unsigned           PSC_W  = A_W + 1;
  localparam logic [PSC_W-1:0]      BASE   = PSC_W'(1 << A_W);
  localparam logic [PSC_W-1:0]      BASE_M1 = BASE - PSC_W'(1);

  logic [PSC_W-1:0] cnt;
  logic [PSC_W-1:0] term;

  always_comb begin
    term = BASE_M1 + PSC_W'(modsel == MOD_HI);
    tick = (cnt == term);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt <= '0;
    else if (hold)   cnt <= '0;
    else if (tick)   cnt <= '0;
    else             cnt <= cnt + PSC_W'(1);
  end

  // R2: the prescaler phase never passes the high modulus terminal value
  p_psc_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= BASE);

  // R5: a held prescaler restarts from phase zero
  p_psc_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    hold |=> cnt == '0);

endmodule

// File: rtl/fbdiv_swallow.sv
module fbdiv_swallow
  import fbdiv_pkg::*;
#(
  parameter int unsigned A_W = DEF_A_W
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           load,
  input  logic [A_W-1:0] a_ld,
  input  logic           tick,
  output modsel_e        modsel
);

  logic [A_W-1:0] cnt;

  // High modulus while swallow cycles remain in this period.
  always_comb modsel = (cnt != '0) ? MOD_HI : MOD_LO;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    cnt <= '0;
    else if (load)                 cnt <= a_ld;
    else if (tick && cnt != '0)    cnt <= cnt - A_W'(1);
  end

  // R4: outside a reload the swallow count moves only on a prescaler tick
  p_swallow_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !tick) |=> $stable(cnt));

endmodule

// File: rtl/fbdiv_main.sv
module fbdiv_main
  import fbdiv_pkg::*;
#(
  parameter int unsigned B_W = DEF_B_W
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           clear,
  input  logic           tick,
  input  logic [B_W-1:0] b_eff,
  output logic           last
);

  logic [B_W-1:0] cnt;

  always_comb last = (cnt == b_eff - B_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt <= '0;
    else if (clear)  cnt <= '0;
    else if (tick)   cnt <= cnt + B_W'(1);
  end

  // R1: the main count stays below the main value in force
  p_b_bound_r1: assert property (@(posedge clk) disable iff (!rst_n)
    cnt < b_eff);

endmodule

// File: rtl/fbdiv_pswallow.sv
module fbdiv_pswallow
  import fbdiv_pkg::*;
#(
  parameter int unsigned A_W = DEF_A_W,
  parameter int unsigned B_W = DEF_B_W
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           srst,
  input  logic           pwr_dn,
  input  logic [A_W-1:0] swallow_a,
  input  logic [B_W-1:0] main_b,
  output logic           div_pulse,
  output logic           cfg_err
);

  logic           armed;
  logic           hold;
  logic           tick;
  logic           b_last;
  logic           period_end;
  logic           reload;
  modsel_e        modsel;
  logic [A_W-1:0] a_nxt;
  logic [A_W-1:0] a_eff;
  logic [B_W-1:0] b_eff;

  // First clock after reset only loads the setting.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armed <= 1'b0;
    else        armed <= 1'b1;
  end

  always_comb begin
    hold       = srst | pwr_dn | !armed;
    period_end = tick & b_last;
    reload     = hold | period_end;
  end

  fbdiv_setting #(.A_W(A_W), .B_W(B_W)) u_setting (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (reload),
    .a_in  (swallow_a),
    .b_in  (main_b),
    .a_nxt (a_nxt),
    .a_eff (a_eff),
    .b_eff (b_eff),
    .err_q (cfg_err)
  );

  fbdiv_prescaler #(.A_W(A_W)) u_psc (
    .clk    (clk),
    .rst_n  (rst_n),
    .hold   (hold),
    .modsel (modsel),
    .tick   (tick)
  );

  fbdiv_swallow #(.A_W(A_W)) u_swallow (
    .clk    (clk),
    .rst_n  (rst_n),
    .load   (reload),
    .a_ld   (a_nxt),
    .tick   (tick),
    .modsel (modsel)
  );

  fbdiv_main #(.B_W(B_W)) u_main (
    .clk   (clk),
    .rst_n (rst_n),
    .clear (reload),
    .tick  (tick),
    .b_eff (b_eff),
    .last  (b_last)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) div_pulse <= 1'b0;
    else        div_pulse <= period_end & !hold;
  end

  // R3: the output pulse never lasts two cycles
  p_one_wide_r3: assert property (@(posedge clk) disable iff (!rst_n)
    div_pulse |=> !div_pulse);

  // R5: power-down silences the output on the next cycle
  p_pd_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_dn |=> !div_pulse);

  // R6: a reset request silences the output on the next cycle
  p_srst_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    srst |=> !div_pulse);

  // R2: the swallow value in force is used as given unless it was clamped
  p_a_kept_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_err |-> B_W'(a_eff) <= b_eff);

endmodule

// File: tb/tb_fbdiv_pswallow.sv
module tb_fbdiv_pswallow;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       srst = 1'b0;
  logic       pwr_dn = 1'b0;
  logic [4:0] swallow_a = '0;
  logic [9:0] main_b = 10'd1;
  logic       div_pulse;
  logic       cfg_err;

  int n_vec = 0;
  int n_bad = 0;
  int cyc = 0;
  bit done = 0;

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  fbdiv_pswallow dut (
    .clk(clk), .rst_n(rst_n), .srst(srst), .pwr_dn(pwr_dn),
    .swallow_a(swallow_a), .main_b(main_b),
    .div_pulse(div_pulse), .cfg_err(cfg_err)
  );

  function automatic int exp_n(int a, int b);
    int be = (b == 0) ? 1 : b;
    int ae = (a > be) ? be : a;
    return 32 * be + ae;
  endfunction

  task automatic check(string req, int act, int exp);
    n_vec++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  // Waits for the next pulse; returns its cycle stamp (-1 on timeout) and width flag.
  task automatic wait_pulse(input int limit, output int t_seen, output bit wide);
    t_seen = -1;
    wide = 0;
    for (int i = 0; i < limit; i++) begin
      @(negedge clk);
      if (div_pulse) begin
        t_seen = cyc;
        @(negedge clk);
        wide = div_pulse;
        return;
      end
    end
  endtask

  task automatic set_cfg(int a, int b);
    swallow_a = 5'(a);
    main_b = 10'(b);
  endtask

  // Power-down hold, then release and measure the first pulse.
  task automatic first_after_pd(string req, int a, int b);
    int base, t;
    bit w;
    @(negedge clk); pwr_dn = 1'b1; set_cfg(a, b);
    repeat (3) @(negedge clk);
    pwr_dn = 1'b0;
    base = cyc;
    wait_pulse(exp_n(a, b) + 10, t, w);
    check(req, (t < 0) ? -1 : t - base, exp_n(a, b));
  endtask

  task automatic t_reset;
    @(negedge clk);
    check("R9 pulse in reset", int'(div_pulse), 0);
    check("R9 err in reset", int'(cfg_err), 0);
  endtask

  task automatic t_after_reset;
    int base, t;
    bit w;
    set_cfg(2, 3);
    @(negedge clk); rst_n = 1'b1;
    base = cyc;
    wait_pulse(200, t, w);
    check("R9 first pulse after reset", (t < 0) ? -1 : t - base, exp_n(2, 3) + 1);
  endtask

  task automatic t_periods(int a, int b);
    int t0, t1;
    bit w;
    first_after_pd("R5 first pulse", a, b);
    check("R1 cfg_err low", int'(cfg_err), 0);
    wait_pulse(exp_n(a, b) + 10, t0, w);
    check("R3 width", int'(w), 0);
    wait_pulse(exp_n(a, b) + 10, t1, w);
    check("R1 spacing", t1 - t0, exp_n(a, b));
  endtask

  task automatic t_range;
    first_after_pd("R2 N=992", 0, 31);
    first_after_pd("R2 N=1023", 31, 31);
    first_after_pd("R2 N=1024", 0, 32);
    first_after_pd("R2 N=32767", 31, 1023);
  endtask

  task automatic t_change;
    int base, t0, t1;
    bit w;
    @(negedge clk); pwr_dn = 1'b1; set_cfg(1, 4);
    repeat (2) @(negedge clk);
    pwr_dn = 1'b0;
    base = cyc;
    repeat (40) @(negedge clk);
    set_cfg(3, 6);
    wait_pulse(300, t0, w);
    check("R4 old period kept", t0 - base, exp_n(1, 4));
    wait_pulse(300, t1, w);
    check("R4 new period used", t1 - t0, exp_n(3, 6));
  endtask

  task automatic t_srst;
    int base, t;
    bit w;
    first_after_pd("R5 pre-srst", 2, 5);
    repeat (70) @(negedge clk);
    srst = 1'b1;
    @(negedge clk); srst = 1'b0;
    base = cyc;
    wait_pulse(300, t, w);
    check("R6 realigned after srst", t - base, exp_n(2, 5));
  endtask

  task automatic t_pd_mid;
    int seen;
    first_after_pd("R5 pre-pd", 0, 2);
    repeat (20) @(negedge clk);
    pwr_dn = 1'b1;
    seen = 0;
    for (int i = 0; i < 150; i++) begin
      @(negedge clk);
      if (div_pulse) seen++;
    end
    check("R5 no pulse in power-down", seen, 0);
    pwr_dn = 1'b0;
    first_after_pd("R5 resume after power-down", 0, 2);
  endtask

  task automatic t_clamp;
    first_after_pd("R7 A>B ratio", 9, 4);
    check("R7 cfg_err", int'(cfg_err), 1);
    first_after_pd("R8 B=0 A=0 ratio", 0, 0);
    check("R8 cfg_err", int'(cfg_err), 1);
    first_after_pd("R8 B=0 A=3 ratio", 3, 0);
    check("R8 cfg_err A=3", int'(cfg_err), 1);
    first_after_pd("R1 valid again", 1, 1);
    check("R1 cfg_err cleared", int'(cfg_err), 0);
  endtask

  initial begin
    repeat (3) t_reset();
    t_after_reset();
    t_periods(2, 3);
    t_periods(0, 5);
    t_periods(7, 7);
    t_range();
    t_change();
    t_srst();
    t_pd_mid();
    t_clamp();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: got %0d expected %0d", cyc, 0);
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

endmodule